// File: doc/BRIEF.md
# Cascaded LED Sink Chain Programmer

This block is the host-side master for a string of cascaded three-channel LED current-sink devices. The devices share a four-wire link: a serial clock, a serial data line, a latch strobe and a blank line. Each device holds three bits in a small shift register. That register feeds its neighbour, and a latch strobe copies it into the channel outputs. The block accepts one channel-enable word with a valid/ready handshake. It then produces the serial clock from the system clock through a parameterised half-period divider and shifts the whole word down the chain. After a short quiet gap it strobes the latch and pulses `done` for one cycle.

The input word uses one bit per channel. Bit `d*CH_PER_DEV + c` drives channel `c` of device `d`, and device 0 is the one wired directly to the host. Back-pressure is simple. `in_ready` is high only while the block is idle, and a word is taken in the cycle where `in_valid` and `in_ready` are both high. While a transfer runs, `in_ready` stays low. The source must hold `in_valid` and `in_data` until `in_ready` returns, and a word offered during that time has no effect on the link. The blank request is a plain control input. It is re-timed by one register and then drives the blank line, which switches every LED off without disturbing any stored bits.

Top module: `led_chain_host`

## Requirements
- R1: During reset and in the first cycle after it, `ser_clk`, `ser_data`, `ser_latch` and `done` are low, `in_ready` is high and `ser_blank` is high.
- R2: `in_ready` is high exactly when the block is idle. A word is accepted only on a clock edge where `in_valid` and `in_ready` are both high. While a transfer is in progress, `in_ready` is low and an offered word is not taken; that word is accepted only after the current transfer's `done` pulse.
- R3: Serial bits leave most significant first, `in_data[NB-1]` down to `in_data[0]`. So the farthest device receives its bits first, and within each device the highest channel goes first.
- R4: The first low half-period of `ser_clk` starts in the cycle after acceptance. Each low and each high half lasts `HALF_DIV` system cycles, low before high, for `NB` periods. Between transfers `ser_clk` stays low.
- R5: `ser_data` changes only when `ser_clk` falls or is idle. It never changes while `ser_clk` is high, so setup and hold at each rising edge are a full half-period.
- R6: After the last high half, `ser_clk` stays low for `HALF_DIV` cycles. Then `ser_latch` is high for `LATCH_CYC` cycles. `ser_latch` and `ser_clk` are never high together.
- R7: `done` is high for exactly one cycle, directly after `ser_latch` falls. `in_ready` returns high in the next cycle.
- R8: `ser_blank` equals `blank_req` one cycle earlier. With blank high, every LED in the chain is off, and after blank is released the previously latched pattern shows again.
- R9: Each serial-clock half lasts at least 18 ns and each period at least 40 ns. The latch is at least 20 ns wide, and the gap before it is at least 8 ns, at the given `SYS_PERIOD_NS`. Parameter sets that break these limits stop elaboration.
- R10: After a transfer, channel `c` of device `d` in the chain shows `in_data[d*CH_PER_DEV + c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Channel word offered |
| in_ready | output | 1 | Block idle, word can be taken |
| in_data | input | N_DEV*CH_PER_DEV | Channel-enable word, bit d*CH_PER_DEV+c for device d channel c |
| blank_req | input | 1 | Request to turn all LEDs off |
| done | output | 1 | One-cycle pulse after the latch strobe |
| ser_clk | output | 1 | Serial clock to the chain |
| ser_data | output | 1 | Serial data to the chain |
| ser_latch | output | 1 | Latch strobe to the chain |
| ser_blank | output | 1 | Blank line to the chain, active high |

## Verification
A transfer accepted at edge t has a fixed schedule. The first low half of the serial clock is visible in the cycle after t. The latch strobe starts `NB*2*HALF_DIV + HALF_DIV` cycles after that, and `done` follows `LATCH_CYC` cycles later. The blank line lags its request by exactly one cycle. The bench drives inputs just after a rising edge and samples at the falling edge. When a word is accepted, its model builds the whole expected cycle-by-cycle waveform and pops one entry per cycle, so every output is compared in the very cycle it is due. The chain of behavioural devices is read after each `done` and around blank changes, which confirms device and channel placement.

// File: rtl/lch_pkg.sv
package lch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_GAP   = 3'd3,
    ST_LATCH = 3'd4,
    ST_DONE  = 3'd5
  } lch_state_e;

  // Link timing limits in nanoseconds
  localparam int MIN_HALF_NS        = 18;
  localparam int MIN_PERIOD_NS      = 40;
  localparam int MIN_LATCH_NS       = 20;
  localparam int MIN_LATCH_SETUP_NS = 8;

endpackage

// File: rtl/lch_phase_timer.sv
module lch_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lch_shift_out.sv
module lch_shift_out #(
  parameter int NB = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NB-1:0] load_data,
  input  logic          advance,
  output logic          bit_o,
  output logic          last_o
);

  localparam int LW = $clog2(NB + 1);

  logic [NB-1:0] word_q;
  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else if (load) begin
      word_q <= load_data;
      left_q <= LW'(NB);
    end else if (advance) begin
      word_q <= {word_q[NB-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o  = word_q[NB-1];
  assign last_o = (left_q == LW'(1));

endmodule

// File: rtl/lch_seq.sv
module lch_seq
  import lch_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int LATCH_CYC = 2,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             expired,
  input  logic             last_bit,
  output lch_state_e       state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             sh_load,
  output logic             sh_adv
);

  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] LATCH_LD = CNT_W'(LATCH_CYC - 1);

  lch_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_adv   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
          sh_load  = 1'b1;
        end
      end
      ST_LOW: begin
        if (expired) begin
          state_d  = ST_HIGH;
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
        end
      end
      ST_HIGH: begin
        if (expired) begin
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
          if (last_bit) begin
            state_d = ST_GAP;
          end else begin
            state_d = ST_LOW;
            sh_adv  = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (expired) begin
          state_d  = ST_LATCH;
          tmr_load = 1'b1;
          tmr_val  = LATCH_LD;
        end
      end
      ST_LATCH: begin
        if (expired) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/led_chain_host.sv
module led_chain_host
  import lch_pkg::*;
#(
  parameter int N_DEV         = 3,
  parameter int CH_PER_DEV    = 3,
  parameter int SYS_PERIOD_NS = 10,
  parameter int HALF_DIV      = 2,
  parameter int LATCH_CYC     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [N_DEV*CH_PER_DEV-1:0] in_data,
  input  logic                        blank_req,
  output logic                        done,
  output logic                        ser_clk,
  output logic                        ser_data,
  output logic                        ser_latch,
  output logic                        ser_blank
);

  localparam int NB     = N_DEV * CH_PER_DEV;
  localparam int MAXC   = (HALF_DIV > LATCH_CYC) ? HALF_DIV : LATCH_CYC;
  localparam int CNT_W  = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam int HALF_NS = HALF_DIV * SYS_PERIOD_NS;

  // Elaboration-time timing guard against the link limits
  if (HALF_DIV < 1 || LATCH_CYC < 1 || NB < 2) begin : g_bad_shape
    $error("led_chain_host: HALF_DIV, LATCH_CYC must be >= 1 and chain at least 2 bits");
  end
  if (HALF_NS < MIN_HALF_NS || 2 * HALF_NS < MIN_PERIOD_NS) begin : g_bad_div
    $error("led_chain_host: serial clock half period too short");
  end
  if (LATCH_CYC * SYS_PERIOD_NS < MIN_LATCH_NS || HALF_NS < MIN_LATCH_SETUP_NS) begin : g_bad_latch
    $error("led_chain_host: latch strobe width or setup too short");
  end

  lch_state_e       state;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_adv, sh_bit, sh_last;
  logic             blank_q;

  lch_seq #(
    .HALF_DIV (HALF_DIV),
    .LATCH_CYC(LATCH_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (in_valid),
    .expired (tmr_exp),
    .last_bit(sh_last),
    .state   (state),
    .tmr_load(tmr_load),
    .tmr_val (tmr_val),
    .sh_load (sh_load),
    .sh_adv  (sh_adv)
  );

  lch_phase_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_exp)
  );

  lch_shift_out #(
    .NB(NB)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_data(in_data),
    .advance  (sh_adv),
    .bit_o    (sh_bit),
    .last_o   (sh_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blank_q <= 1'b1;
    else        blank_q <= blank_req;
  end

  assign in_ready  = (state == ST_IDLE);
  assign ser_clk   = (state == ST_HIGH);
  assign ser_data  = ((state == ST_LOW) || (state == ST_HIGH)) && sh_bit;
  assign ser_latch = (state == ST_LATCH);
  assign done      = (state == ST_DONE);
  assign ser_blank = blank_q;

endmodule

// File: rtl/lch_chk.sv
module lch_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic blank_req,
  input logic done,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_latch,
  input logic ser_blank
);

  logic        seen_edge_q;
  logic [15:0] hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_edge_q <= 1'b0;
      hi_run_q    <= '0;
    end else begin
      seen_edge_q <= 1'b1;
      hi_run_q    <= ser_clk ? hi_run_q + 1'b1 : '0;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!ser_clk && !ser_latch));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  // R6
  latch_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_latch |-> !ser_clk);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));

  // R7
  done_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_latch) |-> done);

  // R8
  blank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge_q |-> (ser_blank == $past(blank_req)));

  // R9
  clk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_clk && hi_run_q != '0) |-> (hi_run_q >= 16'(HALF_DIV)));

endmodule

bind led_chain_host lch_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .blank_req(blank_req),
  .done     (done),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .ser_latch(ser_latch),
  .ser_blank(ser_blank)
);

// File: tb/led_chain_host_tb.sv
module lch_drv_model (
  input  logic       cin,
  input  logic       sin,
  input  logic       lin,
  input  logic       bin,
  output logic       sout,
  output logic [2:0] led
);
  logic [2:0] sreg = 3'b000;
  logic [2:0] lreg = 3'b000;
  initial sout = 1'b0;
  always @(posedge cin) sreg <= {sreg[1:0], sin};
  always @(negedge cin) sout <= sreg[2];
  always @(negedge lin) lreg <= sreg;
  assign led = bin ? 3'b000 : lreg;
endmodule

module led_chain_host_tb;
  localparam int N_DEV = 3;
  localparam int CPD   = 3;
  localparam int NB    = N_DEV * CPD;
  localparam int HALF  = 2;
  localparam int LAT   = 2;
  localparam int TNS   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [NB-1:0] in_data = '0;
  logic blank_req = 1'b0;
  logic in_ready, done, ser_clk, ser_data, ser_latch, ser_blank;

  int checks = 0;
  int errors = 0;
  int accepts = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  led_chain_host #(
    .N_DEV(N_DEV), .CH_PER_DEV(CPD), .SYS_PERIOD_NS(TNS),
    .HALF_DIV(HALF), .LATCH_CYC(LAT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .blank_req(blank_req), .done(done),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_latch(ser_latch),
    .ser_blank(ser_blank)
  );

  // Behavioural chain of devices
  logic [N_DEV:0] link;
  logic [NB-1:0]  leds;
  assign link[0] = ser_data;
  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    lch_drv_model u_dev (
      .cin(ser_clk), .sin(link[d]), .lin(ser_latch), .bin(ser_blank),
      .sout(link[d+1]), .led(leds[d*CPD +: CPD])
    );
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: {sclk, sdata, latch, done, ready} per cycle
  logic [4:0] expq[$];
  logic       prev_blank = 1'b1;
  int         hi_run = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_blank = 1'b1;
      expq.delete();
      hi_run = 0;
    end else begin
      logic [4:0] e;
      e = (expq.size() > 0) ? expq.pop_front() : 5'b00001;
      check("R4", "ser_clk",   ser_clk,   e[4]);
      check("R3", "ser_data",  ser_data,  e[3]);
      check("R6", "ser_latch", ser_latch, e[2]);
      check("R7", "done",      done,      e[1]);
      check("R2", "in_ready",  in_ready,  e[0]);
      check("R8", "ser_blank", ser_blank, prev_blank);
      prev_blank = blank_req;
      if (ser_clk) hi_run++;
      else if (hi_run > 0) begin
        check("R9", "clk high ns >= 18", (hi_run * TNS >= 18), 1);
        hi_run = 0;
      end
      if (in_valid && in_ready) begin
        accepts++;
        for (int i = NB - 1; i >= 0; i--) begin
          for (int k = 0; k < HALF; k++) expq.push_back({1'b0, in_data[i], 3'b000});
          for (int k = 0; k < HALF; k++) expq.push_back({1'b1, in_data[i], 3'b000});
        end
        for (int k = 0; k < HALF; k++) expq.push_back(5'b00000);
        for (int k = 0; k < LAT; k++)  expq.push_back(5'b00100);
        expq.push_back(5'b00010);
      end
    end
  end

  task automatic offer(input logic [NB-1:0] v);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = v;
    do @(negedge clk); while (!in_ready);
  endtask

  task automatic wait_done_chk(input logic [NB-1:0] v, input string req);
    do @(negedge clk); while (!done);
    check(req, "chain leds", leds, v);
  endtask

  task automatic send(input logic [NB-1:0] v);
    offer(v);
    @(posedge clk); #1;
    in_valid = 1'b0;
    wait_done_chk(v, "R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset ser_clk",   ser_clk,   0);
    check("R1", "reset ser_data",  ser_data,  0);
    check("R1", "reset ser_latch", ser_latch, 0);
    check("R1", "reset done",      done,      0);
    check("R1", "reset in_ready",  in_ready,  1);
    check("R1", "reset ser_blank", ser_blank, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;

    send(9'b101_010_011);
    send(9'b111_111_111);
    send(9'b000_000_000);
    send(9'b100_000_001);
    send(9'b010_101_010);

    // R2: second word offered while busy is taken only after done
    begin
      int acc0;
      acc0 = accepts;
      offer(9'b110_001_100);
      @(posedge clk); #1;
      in_data = 9'b001_110_011;
      wait_done_chk(9'b110_001_100, "R2");
      check("R2", "accepts while busy", accepts - acc0, 1);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
      wait_done_chk(9'b001_110_011, "R10");
      check("R2", "accepts total", accepts - acc0, 2);
    end

    // R8: blank forces off and keeps stored data
    @(posedge clk); #1;
    blank_req = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", "leds under blank", leds, 0);
    @(posedge clk); #1;
    blank_req = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", "leds after blank", leds, 9'b001_110_011);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule